// File: doc/BRIEF.md
# Seven-Channel DMA Register and Completion Unit

This block holds the programming registers of a seven-channel DMA controller and decides when each transfer finishes. Software reaches it through a word-addressed register port with per-byte write strobes. Each channel owns three registers: a memory address, a block control word that gives block size and block count, and a channel control word. The channel control word holds a direction bit and a start/busy bit. An eighth register slot holds a general control register and a shared interrupt register. The interrupt register has one byte of per-channel enables and one byte of per-channel completion flags.

Setting the start bit of a channel with a non-zero transfer length sends a one-cycle launch descriptor to the data mover: channel, word-aligned address inside a 2 MB window, byte length and direction. It also loads that channel's completion down-counter. When the counter expires, the busy bit drops. If the channel's enable is set, its flag is raised and a single-cycle interrupt request is pulsed. The completion-mode input selects between a minimal one-cycle completion and a length-proportional delay of eight cycles per 16-bit halfword. All seven counters run independently.

Top module: `dmac_regs`

## Requirements
- R1: After reset every register reads zero and `irq` and `launch_valid` are low. `rd_data` is zero in any cycle that follows a cycle without `req_rd`.
- R2: `req_word_addr[4:2]` selects the slot and `req_word_addr[1:0]` the word. In slots 0..6, word 0 is the address, word 1 is the block control and word 2 is the channel control. In slot 7, word 0 is a plain 32-bit general control register and word 1 is the interrupt register. Slot 7 word 2 and word 3 of every slot read zero and ignore writes.
- R3: Writes change only the bytes whose `req_strb` bit is set. Reads return the register value with unstrobed bytes forced to zero, one cycle after `req_rd`.
- R4: A start on a non-zero length pulses `launch_valid` in the cycle after the write. The pulse carries `launch_chan` = slot and `launch_len` = 4 × size × count, where size is bits 15:0 and count is bits 31:16 of the block control. It also carries `launch_addr` = address bits 20:2 with bits 1:0 zero, and `launch_dir` = channel control bit 0.
- R5: A start with zero length raises no launch, never completes and never interrupts. Channel control bit 24 stays set.
- R6: With `delayed_mode` low at the start, completion happens one cycle after the start write. `irq` is then high in the second cycle after the write.
- R7: With `delayed_mode` high at the start, completion happens 16 × size × count cycles after the start write. That is eight cycles per halfword.
- R8: Completion clears channel control bit 24 and leaves the other channel control bits unchanged.
- R9: At completion, if enable bit 16+ch of the interrupt register is set, flag bit 24+ch is set and `irq` is high for exactly one cycle. If the enable bit is clear, neither happens.
- R10: Writing the enable byte (strobe 2) ORs its bits into the enables, so enables are never cleared. Writing the flag byte (strobe 3) clears the flags written as 1. Bytes 0 and 1 of the interrupt register read zero.
- R11: Several channels may count at once. Channels finishing in the same cycle set all their flags and produce one `irq` pulse.
- R12: A flag set by completion in the same cycle as a flag-clearing write survives that write.
- R13: A transfer starts only on a channel control write with strobe 3 set and data bit 24 at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_wr | input | 1 | Register write request |
| req_rd | input | 1 | Register read request |
| req_word_addr | input | 5 | Word address: slot in [4:2], word in [1:0] |
| req_wdata | input | 32 | Write data |
| req_strb | input | 4 | Byte-lane strobes for writes and read masking |
| delayed_mode | input | 1 | Completion mode sampled at start: 0 immediate, 1 length-proportional |
| rd_data | output | 32 | Registered, masked read data |
| irq | output | 1 | One-cycle DMA interrupt request |
| launch_valid | output | 1 | One-cycle launch descriptor strobe |
| launch_chan | output | 3 | Channel being launched |
| launch_addr | output | 21 | Word-aligned address within the 2 MB window |
| launch_len | output | 34 | Transfer length in bytes |
| launch_dir | output | 1 | Direction bit of the launched channel |

## Verification
Two events can coincide: a channel's completion setting its flag, and a software write clearing the flag byte of the interrupt register. The bench provokes this by starting a channel in immediate mode and issuing a clear-all-flags write on the very next edge. That edge is the one where the completion lands. The bench then reads the interrupt register and expects the new flag to be present while an older flag is gone. A second coincidence, two channels finishing on the same edge, is staged by staggering their starts by the difference of their delays. The bench counts that exactly one `irq` pulse appears.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  localparam int WORD_W    = 32;
  localparam int LEN_W     = 34;
  localparam int START_BIT = 24;
  localparam int DIR_BIT   = 0;
  localparam int EN_LSB    = 16;
  localparam int FLAG_LSB  = 24;

  typedef enum logic [1:0] {
    WSEL_ADDR  = 2'd0,
    WSEL_BLOCK = 2'd1,
    WSEL_CTRL  = 2'd2,
    WSEL_NONE  = 2'd3
  } word_sel_e;

  function automatic logic [WORD_W-1:0] lane_mask(input logic [3:0] strb);
    logic [WORD_W-1:0] m;
    for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{strb[b]}};
    return m;
  endfunction

  function automatic logic [WORD_W-1:0] masked_merge(input logic [WORD_W-1:0] old_v,
                                                     input logic [WORD_W-1:0] new_v,
                                                     input logic [WORD_W-1:0] m);
    return (old_v & ~m) | (new_v & m);
  endfunction

endpackage

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
#(
  parameter int WIN_BITS = 21,
  parameter int HW_CYC   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  word_sel_e           wsel,
  input  logic [WORD_W-1:0]   wdata,
  input  logic [WORD_W-1:0]   wmask,
  input  logic                delayed,
  output logic [WORD_W-1:0]   addr_q,
  output logic [WORD_W-1:0]   block_q,
  output logic [WORD_W-1:0]   ctrl_q,
  output logic                done,
  output logic                launch_now,
  output logic [LEN_W-1:0]    launch_len,
  output logic [WIN_BITS-1:0] launch_addr,
  output logic                launch_dir
);

  localparam int CNT_W = LEN_W + $clog2(HW_CYC) + 1;

  logic [WORD_W-1:0] ctrl_merged;
  logic [WORD_W-1:0] ctrl_next;
  logic [31:0]       prod;
  logic              len_nz;
  logic              start;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  delay_val;

  assign ctrl_merged = masked_merge(ctrl_q, wdata, wmask);
  assign start       = wr_en && (wsel == WSEL_CTRL) && wmask[START_BIT] && wdata[START_BIT];
  assign prod        = 32'(block_q[15:0]) * 32'(block_q[31:16]);
  assign len_nz      = (prod != '0);
  assign delay_val   = delayed ? CNT_W'(HW_CYC) * CNT_W'({prod, 1'b0}) : CNT_W'(1);
  assign done        = (cnt == CNT_W'(1)) && !start;

  assign launch_now  = start && len_nz;
  assign launch_len  = {prod, 2'b00};
  assign launch_addr = {addr_q[WIN_BITS-1:2], 2'b00};
  assign launch_dir  = ctrl_merged[DIR_BIT];

  always_comb begin
    ctrl_next = ctrl_q;
    if (wr_en && wsel == WSEL_CTRL) ctrl_next = ctrl_merged;
    if (done) ctrl_next[START_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      block_q <= '0;
      ctrl_q  <= '0;
      cnt     <= '0;
    end else begin
      if (wr_en && wsel == WSEL_ADDR)  addr_q  <= masked_merge(addr_q, wdata, wmask);
      if (wr_en && wsel == WSEL_BLOCK) block_q <= masked_merge(block_q, wdata, wmask);
      ctrl_q <= ctrl_next;
      if (start)           cnt <= len_nz ? delay_val : '0;
      else if (cnt != '0)  cnt <= cnt - CNT_W'(1);
    end
  end

  // R8: completion drops the busy bit
  a_r8_done_clears_busy: assert property (@(posedge clk) disable iff (rst)
    done |=> !ctrl_q[START_BIT]);

  // R5: a zero-length start leaves the counter idle
  a_r5_zero_len_idle: assert property (@(posedge clk) disable iff (rst)
    (start && !len_nz) |=> (cnt == '0));

  // R6: immediate mode completes on the following edge
  a_r6_immediate_next: assert property (@(posedge clk) disable iff (rst)
    (start && len_nz && !delayed) |=> (cnt == CNT_W'(1)));

  // R7: the counter moves down by one each cycle unless reloaded
  a_r7_count_down: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0 && !start) |=> (cnt == $past(cnt) - CNT_W'(1)));

endmodule

// File: rtl/dmac_shared.sv
module dmac_shared
  import dmac_pkg::*;
#(
  parameter int NCH = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  word_sel_e         wsel,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] wmask,
  input  logic [NCH-1:0]    done_vec,
  output logic [WORD_W-1:0] gen_q,
  output logic [WORD_W-1:0] intr_rd,
  output logic              irq
);

  logic [7:0]     en_q;
  logic [NCH-1:0] flag_q;
  logic [NCH-1:0] flag_set;
  logic [NCH-1:0] flag_clr;
  logic           wr_intr;

  assign wr_intr  = wr_en && (wsel == WSEL_BLOCK);
  assign flag_set = done_vec & en_q[NCH-1:0];
  assign flag_clr = (wr_intr && wmask[FLAG_LSB]) ? wdata[FLAG_LSB +: NCH] : '0;

  always_comb begin
    intr_rd = '0;
    intr_rd[EN_LSB +: 8]     = en_q;
    intr_rd[FLAG_LSB +: NCH] = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_q  <= '0;
      en_q   <= '0;
      flag_q <= '0;
      irq    <= 1'b0;
    end else begin
      if (wr_en && wsel == WSEL_ADDR) gen_q <= masked_merge(gen_q, wdata, wmask);
      if (wr_intr && wmask[EN_LSB])   en_q  <= en_q | wdata[EN_LSB +: 8];
      flag_q <= (flag_q & ~flag_clr) | flag_set;
      irq    <= |flag_set;
    end
  end

  // R9: an interrupt pulse always comes with a flag set on the same edge
  a_r9_irq_has_flag: assert property (@(posedge clk) disable iff (rst)
    irq |-> (flag_q != '0));

  // R10: enable bits are never cleared
  a_r10_enable_sticky: assert property (@(posedge clk) disable iff (rst)
    (!rst) |=> ((en_q & $past(en_q)) == $past(en_q)));

  // R12: completion that meets a clear keeps its flag
  a_r12_set_wins: assert property (@(posedge clk) disable iff (rst)
    (flag_set != '0) |=> ((flag_q & $past(flag_set)) == $past(flag_set)));

endmodule

// File: rtl/dmac_regs.sv
module dmac_regs
  import dmac_pkg::*;
#(
  parameter int NCH      = 7,
  parameter int WIN_BITS = 21,
  parameter int HW_CYC   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_wr,
  input  logic                req_rd,
  input  logic [4:0]          req_word_addr,
  input  logic [31:0]         req_wdata,
  input  logic [3:0]          req_strb,
  input  logic                delayed_mode,
  output logic [31:0]         rd_data,
  output logic                irq,
  output logic                launch_valid,
  output logic [2:0]          launch_chan,
  output logic [WIN_BITS-1:0] launch_addr,
  output logic [33:0]         launch_len,
  output logic                launch_dir
);

  localparam int SLOT_W = 3;
  localparam logic [SLOT_W-1:0] SHARED_SLOT = '1;

  logic [SLOT_W-1:0] slot;
  word_sel_e         wsel;
  logic [WORD_W-1:0] wmask;

  assign slot  = req_word_addr[4:2];
  assign wsel  = word_sel_e'(req_word_addr[1:0]);
  assign wmask = lane_mask(req_strb);

  logic [WORD_W-1:0]   addr_a   [NCH];
  logic [WORD_W-1:0]   block_a  [NCH];
  logic [WORD_W-1:0]   ctrl_a   [NCH];
  logic [LEN_W-1:0]    len_a    [NCH];
  logic [WIN_BITS-1:0] laddr_a  [NCH];
  logic [NCH-1:0]      done_vec;
  logic [NCH-1:0]      launch_vec;
  logic [NCH-1:0]      ldir_vec;

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    dmac_chan #(.WIN_BITS(WIN_BITS), .HW_CYC(HW_CYC)) u_chan (
      .clk        (clk),
      .rst        (rst),
      .wr_en      (req_wr && (slot == SLOT_W'(i))),
      .wsel       (wsel),
      .wdata      (req_wdata),
      .wmask      (wmask),
      .delayed    (delayed_mode),
      .addr_q     (addr_a[i]),
      .block_q    (block_a[i]),
      .ctrl_q     (ctrl_a[i]),
      .done       (done_vec[i]),
      .launch_now (launch_vec[i]),
      .launch_len (len_a[i]),
      .launch_addr(laddr_a[i]),
      .launch_dir (ldir_vec[i])
    );
  end

  logic [WORD_W-1:0] gen_q;
  logic [WORD_W-1:0] intr_rd;

  dmac_shared #(.NCH(NCH)) u_shared (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (req_wr && (slot == SHARED_SLOT)),
    .wsel    (wsel),
    .wdata   (req_wdata),
    .wmask   (wmask),
    .done_vec(done_vec),
    .gen_q   (gen_q),
    .intr_rd (intr_rd),
    .irq     (irq)
  );

  logic [WORD_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NCH; i++) begin
      if (slot == SLOT_W'(i)) begin
        case (wsel)
          WSEL_ADDR:  rd_mux = addr_a[i];
          WSEL_BLOCK: rd_mux = block_a[i];
          WSEL_CTRL:  rd_mux = ctrl_a[i];
          default:    rd_mux = '0;
        endcase
      end
    end
    if (slot == SHARED_SLOT) begin
      case (wsel)
        WSEL_ADDR:  rd_mux = gen_q;
        WSEL_BLOCK: rd_mux = intr_rd;
        default:    rd_mux = '0;
      endcase
    end
  end

  logic                l_any;
  logic [2:0]          l_chan;
  logic [WIN_BITS-1:0] l_addr;
  logic [LEN_W-1:0]    l_len;
  logic                l_dir;

  always_comb begin
    l_any  = 1'b0;
    l_chan = '0;
    l_addr = '0;
    l_len  = '0;
    l_dir  = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (launch_vec[i]) begin
        l_any  = 1'b1;
        l_chan = 3'(i);
        l_addr = laddr_a[i];
        l_len  = len_a[i];
        l_dir  = ldir_vec[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data      <= '0;
      launch_valid <= 1'b0;
      launch_chan  <= '0;
      launch_addr  <= '0;
      launch_len   <= '0;
      launch_dir   <= 1'b0;
    end else begin
      rd_data      <= req_rd ? (rd_mux & wmask) : '0;
      launch_valid <= l_any;
      if (l_any) begin
        launch_chan <= l_chan;
        launch_addr <= l_addr;
        launch_len  <= l_len;
        launch_dir  <= l_dir;
      end
    end
  end

  // R1: idle read port returns zero
  a_r1_read_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !req_rd |=> (rd_data == '0));

  // R13: a launch only follows a control write with the start lane strobed
  a_r13_launch_needs_write: assert property (@(posedge clk) disable iff (rst)
    !(req_wr && req_strb[3]) |=> !launch_valid);

  // R4: launched address is word aligned
  a_r4_launch_aligned: assert property (@(posedge clk) disable iff (rst)
    launch_valid |-> (launch_addr[1:0] == 2'b00 && launch_len[1:0] == 2'b00));

endmodule

// File: tb/dmac_regs_test.sv
module dmac_regs_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_wr = 1'b0;
  logic        req_rd = 1'b0;
  logic [4:0]  req_word_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_strb = '0;
  logic        delayed_mode = 1'b0;
  logic [31:0] rd_data;
  logic        irq;
  logic        launch_valid;
  logic [2:0]  launch_chan;
  logic [20:0] launch_addr;
  logic [33:0] launch_len;
  logic        launch_dir;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dmac_regs uut (
    .clk(clk), .rst(rst), .req_wr(req_wr), .req_rd(req_rd),
    .req_word_addr(req_word_addr), .req_wdata(req_wdata), .req_strb(req_strb),
    .delayed_mode(delayed_mode), .rd_data(rd_data), .irq(irq),
    .launch_valid(launch_valid), .launch_chan(launch_chan),
    .launch_addr(launch_addr), .launch_len(launch_len), .launch_dir(launch_dir)
  );

  function automatic logic [4:0] wa(input int s, input int w);
    return {3'(s), 2'(w)};
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] s);
    req_wr = 1'b1; req_word_addr = a; req_wdata = d; req_strb = s;
    @(posedge clk);
    @(negedge clk);
    req_wr = 1'b0; req_strb = '0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [3:0] s, output logic [31:0] d);
    req_rd = 1'b1; req_word_addr = a; req_strb = s;
    @(posedge clk);
    @(negedge clk);
    d = rd_data;
    req_rd = 1'b0; req_strb = '0;
  endtask

  // counts cycles from the start write until the irq pulse
  task automatic wait_irq(input int limit, output int k);
    k = 0;
    while (k < limit) begin
      @(negedge clk);
      k++;
      if (irq) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int k;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset values across the whole map
    for (int s = 0; s < 8; s++)
      for (int w = 0; w < 4; w++) begin
        rd(wa(s, w), 4'hF, d);
        check(d == 0, "R1 reset read", d, 0);
      end
    check(irq == 0 && launch_valid == 0, "R1 outputs idle", {irq, launch_valid}, 0);
    @(negedge clk);
    check(rd_data == 0, "R1 idle read data", rd_data, 0);

    // R2: distinct patterns in every channel register
    for (int c = 0; c < 7; c++) begin
      wr(wa(c, 0), 32'h1000_0000 + 32'(c), 4'hF);
      wr(wa(c, 1), 32'h0000_2000 + 32'(c), 4'hF);
      wr(wa(c, 2), 32'h0000_0300 + 32'(c), 4'hF);
      wr(wa(c, 3), 32'hFFFF_FFFF, 4'hF);
    end
    for (int c = 0; c < 7; c++) begin
      rd(wa(c, 0), 4'hF, d); check(d == 32'h1000_0000 + 32'(c), "R2 address reg", d, 32'h1000_0000 + 32'(c));
      rd(wa(c, 1), 4'hF, d); check(d == 32'h0000_2000 + 32'(c), "R2 block reg", d, 32'h0000_2000 + 32'(c));
      rd(wa(c, 2), 4'hF, d); check(d == 32'h0000_0300 + 32'(c), "R2 ctrl reg", d, 32'h0000_0300 + 32'(c));
      rd(wa(c, 3), 4'hF, d); check(d == 0, "R2 word3 zero", d, 0);
    end
    wr(wa(7, 0), 32'h1234_5678, 4'hF);
    wr(wa(7, 2), 32'hFFFF_FFFF, 4'hF);
    rd(wa(7, 0), 4'hF, d); check(d == 32'h1234_5678, "R2 general reg", d, 32'h1234_5678);
    rd(wa(7, 2), 4'hF, d); check(d == 0, "R2 slot7 word2 zero", d, 0);

    // R3: byte lane merge and read mask
    wr(wa(5, 0), 32'hAABB_CCDD, 4'hF);
    wr(wa(5, 0), 32'h1122_3344, 4'b0101);
    rd(wa(5, 0), 4'hF, d); check(d == 32'hAA22_CC44, "R3 write lanes", d, 32'hAA22_CC44);
    rd(wa(5, 0), 4'b0011, d); check(d == 32'h0000_CC44, "R3 read lanes", d, 32'h0000_CC44);
    wr(wa(7, 0), 32'h0000_0000, 4'b1000);
    rd(wa(7, 0), 4'hF, d); check(d == 32'h0034_5678, "R3 general lanes", d, 32'h0034_5678);

    // R9: disabled channel completes silently
    delayed_mode = 1'b0;
    wr(wa(2, 1), 32'h0001_0001, 4'hF);
    wr(wa(2, 2), 32'h0100_0000, 4'hF);
    wait_irq(6, k);
    check(k == 6 && !irq, "R9 no irq when disabled", k, 6);
    rd(wa(2, 2), 4'hF, d); check(d == 0, "R8 busy cleared disabled", d, 0);
    rd(wa(7, 1), 4'hF, d); check(d == 0, "R9 no flag when disabled", d, 0);

    // R10: enables OR in, writing zero keeps them
    wr(wa(7, 1), 32'h0004_0000, 4'b0100);
    wr(wa(7, 1), 32'h0000_0000, 4'b0100);
    wr(wa(7, 1), 32'h0000_FFFF, 4'b0011);
    rd(wa(7, 1), 4'hF, d); check(d == 32'h0004_0000, "R10 enable sticky", d, 32'h0004_0000);
    wr(wa(7, 1), 32'h007B_0000, 4'b0100);
    rd(wa(7, 1), 4'hF, d); check(d == 32'h007F_0000, "R10 enable or", d, 32'h007F_0000);

    // R13: start bit without lane 3 strobe does nothing
    wr(wa(1, 1), 32'h0001_0001, 4'hF);
    wr(wa(1, 2), 32'h0100_0001, 4'b0111);
    check(!launch_valid, "R13 no launch without lane", launch_valid, 0);
    wait_irq(4, k);
    check(k == 4 && !irq, "R13 no completion", k, 4);
    rd(wa(1, 2), 4'hF, d); check(d == 32'h0000_0001, "R13 ctrl value", d, 1);

    // R5: zero length start
    wr(wa(4, 1), 32'h0003_0000, 4'hF);
    wr(wa(4, 2), 32'h0100_0000, 4'hF);
    check(!launch_valid, "R5 no launch", launch_valid, 0);
    wait_irq(40, k);
    check(k == 40 && !irq, "R5 never completes", k, 40);
    rd(wa(4, 2), 4'hF, d); check(d == 32'h0100_0000, "R5 busy stays", d, 32'h0100_0000);
    rd(wa(7, 1), 4'hF, d); check(d == 32'h007F_0000, "R5 no flag", d, 32'h007F_0000);
    wr(wa(4, 2), 32'h0, 4'hF);

    // R4 R6 R7 R8 R9: sweep channels, sizes, counts and both modes
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 7; c++)
        for (int s = 1; s <= 3; s++)
          for (int n = 1; n <= 3; n++) begin
            logic [31:0] ad;
            logic [31:0] cw;
            int exp_d;
            ad = 32'hFFE0_0003 + 32'(c * 256 + s * 16 + n * 4) + (32'(m) << 28);
            cw = 32'h0100_0000 | 32'(c << 8) | 32'((c + s + n + m) & 1);
            exp_d = (m == 1) ? 16 * s * n : 1;
            delayed_mode = (m == 1);
            wr(wa(c, 0), ad, 4'hF);
            wr(wa(c, 1), (32'(n) << 16) | 32'(s), 4'hF);
            wr(wa(c, 2), cw, 4'hF);
            check(launch_valid && launch_chan == 3'(c), "R4 launch chan", launch_chan, c);
            check(launch_len == 34'(4 * s * n), "R4 launch len", launch_len, 4 * s * n);
            check(launch_addr == {ad[20:2], 2'b00}, "R4 launch addr", launch_addr, {ad[20:2], 2'b00});
            check(launch_dir == cw[0], "R4 launch dir", launch_dir, cw[0]);
            wait_irq(exp_d + 3, k);
            check(k == exp_d, m ? "R7 delayed timing" : "R6 immediate timing", k, exp_d);
            @(negedge clk);
            check(!irq, "R9 single cycle irq", irq, 0);
            rd(wa(c, 2), 4'hF, d);
            check(d == (cw & ~32'h0100_0000), "R8 busy cleared", d, cw & ~32'h0100_0000);
            rd(wa(7, 1), 4'hF, d);
            check(d == (32'h007F_0000 | (32'h0100_0000 << c)), "R9 flag set", d, 32'h007F_0000 | (32'h0100_0000 << c));
            wr(wa(7, 1), 32'h7F00_0000, 4'b1000);
          end

    // R10: selective flag clear
    delayed_mode = 1'b0;
    wr(wa(0, 1), 32'h0001_0001, 4'hF);
    wr(wa(6, 1), 32'h0001_0001, 4'hF);
    wr(wa(0, 2), 32'h0100_0000, 4'hF);
    wr(wa(6, 2), 32'h0100_0000, 4'hF);
    repeat (2) @(negedge clk);
    wr(wa(7, 1), 32'h4000_0000, 4'b1000);
    rd(wa(7, 1), 4'hF, d); check(d == 32'h017F_0000, "R10 clear one flag", d, 32'h017F_0000);

    // R12: completion and clear on the same edge; old ch0 flag goes, ch3 stays
    wr(wa(3, 1), 32'h0001_0001, 4'hF);
    wr(wa(3, 2), 32'h0100_0000, 4'hF);
    wr(wa(7, 1), 32'h7F00_0000, 4'b1000);
    check(irq, "R12 irq on collision", irq, 1);
    rd(wa(7, 1), 4'hF, d); check(d == 32'h087F_0000, "R12 set wins", d, 32'h087F_0000);
    wr(wa(7, 1), 32'h7F00_0000, 4'b1000);

    // R11: two channels finish on the same edge
    begin
      int pulses;
      delayed_mode = 1'b1;
      wr(wa(0, 1), 32'h0002_0001, 4'hF);
      wr(wa(1, 1), 32'h0001_0001, 4'hF);
      wr(wa(0, 2), 32'h0100_0000, 4'hF);
      repeat (15) @(negedge clk);
      wr(wa(1, 2), 32'h0100_0000, 4'hF);
      pulses = 0;
      for (int i = 0; i < 24; i++) begin
        @(negedge clk);
        if (irq) pulses++;
        if (i == 15) check(irq, "R11 joint completion cycle", irq, 1);
      end
      check(pulses == 1, "R11 single pulse", pulses, 1);
      rd(wa(7, 1), 4'hF, d); check(d == 32'h037F_0000, "R11 both flags", d, 32'h037F_0000);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule